// File: doc/BRIEF.md
# Cascaded 8:1 DDR Output Serializer

The block turns one 8-bit parallel word per period of a slow clock into a serial stream that carries one bit on every edge of a fast clock. The fast clock runs at four times the slow rate, so each fast cycle carries two bits: one in its high phase and one in its low phase. A word is placed on `par_din` after one rising edge of the slow clock and is taken in on the next one. Its first bit reaches `ser_out` exactly four fast cycles after that capture edge. Successive words follow one another with no idle bit between them.

Inside, the word is divided between two chained 6-input serializer slices. A primary slice holds the six lower bits and drives the output. A secondary slice holds the two upper bits and passes them into the primary slice's shift chain over a cascade link, so they leave last. The two clocks are assumed phase-aligned. The fast domain finds each slow rising edge by watching the slow clock level on its falling edges, and uses that to time the parallel load.

Top module: `ddr_cascade_serializer`

## Requirements
- R1: `par_din` is captured only at the rising edge of `clk_slow`. Values held on `par_din` between two rising edges have no effect on the stream.
- R2: Within a word, bit `par_din[2m]` is sent in the high phase of the m-th fast cycle of its slot and `par_din[2m+1]` in the low phase of that cycle (m = 0..3). The bit order is therefore index 0 first through index 7 last.
- R3: Bit 0 of a captured word appears at `ser_out` in the high phase that begins exactly four fast-clock cycles after the slow rising edge that captured it.
- R4: Bits 0..5 are serialized by the primary slice. Bits 6 and 7 are held by the secondary slice and enter the primary shift chain over the cascade link, appearing in the last fast cycle of the word's slot.
- R5: Words captured on consecutive slow edges are sent back to back. Bit 0 of the next word directly follows bit 7 of the previous word.
- R6: While `rst` is high, all registers are cleared and `ser_out` is 0.
- R7: After `rst` falls, `ser_out` stays 0 until the first word captured after the release reaches it. Words captured before or during reset never appear.
- R8: The internal parallel load fires exactly once every four fast cycles once the slow clock has been tracked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Bit clock; both edges carry data, 4x the slow rate |
| clk_slow | input | 1 | Word clock, phase-aligned with `clk_fast` |
| rst | input | 1 | Active-high asynchronous reset |
| par_din | input | 8 | Parallel word, bit 0 sent first |
| ser_out | output | 1 | DDR serial output |

## Verification
A wrong load phase or a slip in the edge tracker moves every bit by whole fast cycles. This shows on the first word after reset as a latency error at bit 0. A broken cascade link corrupts only bits 6 and 7 of every word, one fast cycle before the next word starts. A mixed-up pair slot or DDR register swaps adjacent bits within half a fast cycle. A reset that fails to flush the pipeline lets stale bits leak out during the first slow period after release.

// File: rtl/dcs_pkg.sv
`timescale 1ns/1ps
package dcs_pkg;

  // Two bits leave the serializer per fast cycle: [0] high phase, [1] low phase.
  typedef logic [1:0] pair_t;

  // Number of shift slots a slice keeps. The primary slice emits its first
  // pair straight from the staging register, so it needs one slot less.
  function automatic int slot_count(input int n_in, input bit primary);
    return primary ? (n_in / 2) - 1 : (n_in / 2);
  endfunction

  // Phase counter step, wrapping after a full word period.
  function automatic int phase_next(input int ph, input int pairs);
    return (ph == pairs - 1) ? 0 : ph + 1;
  endfunction

endpackage

// File: rtl/dcs_edge_track.sv
`timescale 1ns/1ps
module dcs_edge_track #(
  parameter int PAIRS = 4
) (
  input  logic clk_fast,
  input  logic clk_slow,
  input  logic rst,
  output logic load_o,
  output logic stage_o
);
  import dcs_pkg::*;

  localparam int PH_W   = (PAIRS > 1) ? $clog2(PAIRS) : 1;
  localparam int RUN_W  = $clog2(PAIRS) + 1;
  localparam int LOW_N  = PAIRS / 2;
  localparam int STAGE_PH = PAIRS / 2;

  // Count consecutive low samples of the slow clock on fast falling edges.
  logic [RUN_W-1:0] low_run_q;
  always_ff @(negedge clk_fast or posedge rst) begin
    if (rst) begin
      low_run_q <= '0;
    end else if (clk_slow) begin
      low_run_q <= '0;
    end else if (low_run_q != RUN_W'(LOW_N)) begin
      low_run_q <= low_run_q + 1'b1;
    end
  end

  // Full low half seen: this fast rising edge coincides with a slow rising edge.
  logic slow_rise_w;
  assign slow_rise_w = (low_run_q == RUN_W'(LOW_N));

  logic [PH_W-1:0] phase_q;
  always_ff @(posedge clk_fast or posedge rst) begin
    if (rst) begin
      phase_q <= '0;
    end else if (slow_rise_w) begin
      phase_q <= PH_W'(1);
    end else begin
      phase_q <= PH_W'(phase_next(int'(phase_q), PAIRS));
    end
  end

  assign load_o  = slow_rise_w;
  // Mid-period: the slow-domain capture register is stable here.
  assign stage_o = (phase_q == PH_W'(STAGE_PH));

endmodule

// File: rtl/dcs_slice.sv
`timescale 1ns/1ps
module dcs_slice #(
  parameter int N_IN    = 6,
  parameter bit PRIMARY = 1'b1
) (
  input  logic              clk_fast,
  input  logic              rst,
  input  logic              stage_en,
  input  logic              load,
  input  logic [N_IN-1:0]   par_i,
  input  dcs_pkg::pair_t    casc_i,
  output logic [N_IN-1:0]   stage_o,
  output dcs_pkg::pair_t    head_o,
  output dcs_pkg::pair_t    tail_o
);
  import dcs_pkg::*;

  localparam int N_SLOTS = slot_count(N_IN, PRIMARY);
  localparam int FIRST   = PRIMARY ? 1 : 0;

  logic [N_IN-1:0] stage_q;
  always_ff @(posedge clk_fast or posedge rst) begin
    if (rst)           stage_q <= '0;
    else if (stage_en) stage_q <= par_i;
  end
  assign stage_o = stage_q;

  pair_t slot_q [N_SLOTS];

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
    pair_t fill_w;
    if (i == N_SLOTS - 1) begin : g_last
      assign fill_w = casc_i;          // cascade link enters at the tail
    end else begin : g_mid
      assign fill_w = slot_q[i+1];
    end
    always_ff @(posedge clk_fast or posedge rst) begin
      if (rst)       slot_q[i] <= '0;
      else if (load) slot_q[i] <= stage_q[2*(FIRST+i) +: 2];
      else           slot_q[i] <= fill_w;
    end
  end

  if (PRIMARY) begin : g_head_primary
    assign head_o = load ? stage_q[1:0] : slot_q[0];
  end else begin : g_head_secondary
    assign head_o = slot_q[0];
  end

  assign tail_o = slot_q[N_SLOTS-1];

endmodule

// File: rtl/dcs_ddr_out.sv
`timescale 1ns/1ps
module dcs_ddr_out (
  input  logic           clk_fast,
  input  logic           rst,
  input  dcs_pkg::pair_t pair_i,
  output logic           rise_o,
  output logic           fall_o,
  output logic           ser_o
);
  logic rise_q, pend_q, fall_q;

  always_ff @(posedge clk_fast or posedge rst) begin
    if (rst) begin
      rise_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      rise_q <= pair_i[0];
      pend_q <= pair_i[1];
    end
  end

  // Retime the odd bit to the falling edge so it is stable for the low phase.
  always_ff @(negedge clk_fast or posedge rst) begin
    if (rst) fall_q <= 1'b0;
    else     fall_q <= pend_q;
  end

  assign rise_o = rise_q;
  assign fall_o = fall_q;
  assign ser_o  = clk_fast ? rise_q : fall_q;

endmodule

// File: rtl/ddr_cascade_serializer.sv
`timescale 1ns/1ps
module ddr_cascade_serializer #(
  parameter int WORD_W   = 8,
  parameter int MASTER_W = 6
) (
  input  logic              clk_fast,
  input  logic              clk_slow,
  input  logic              rst,
  input  logic [WORD_W-1:0] par_din,
  output logic              ser_out
);
  import dcs_pkg::*;

  localparam int SLAVE_W = WORD_W - MASTER_W;
  localparam int PAIRS   = WORD_W / 2;

  // Slow-domain capture of the parallel word.
  logic [WORD_W-1:0] cap_q;
  always_ff @(posedge clk_slow or posedge rst) begin
    if (rst) cap_q <= '0;
    else     cap_q <= par_din;
  end

  logic load_w, stage_en_w;
  dcs_edge_track #(.PAIRS(PAIRS)) u_track (
    .clk_fast (clk_fast),
    .clk_slow (clk_slow),
    .rst      (rst),
    .load_o   (load_w),
    .stage_o  (stage_en_w)
  );

  logic [MASTER_W-1:0] m_stage;
  logic [SLAVE_W-1:0]  s_stage;
  pair_t m_head, m_tail, s_head, s_tail;

  dcs_slice #(.N_IN(SLAVE_W), .PRIMARY(1'b0)) u_secondary (
    .clk_fast (clk_fast),
    .rst      (rst),
    .stage_en (stage_en_w),
    .load     (load_w),
    .par_i    (cap_q[WORD_W-1:MASTER_W]),
    .casc_i   (2'b00),
    .stage_o  (s_stage),
    .head_o   (s_head),
    .tail_o   (s_tail)
  );

  dcs_slice #(.N_IN(MASTER_W), .PRIMARY(1'b1)) u_primary (
    .clk_fast (clk_fast),
    .rst      (rst),
    .stage_en (stage_en_w),
    .load     (load_w),
    .par_i    (cap_q[MASTER_W-1:0]),
    .casc_i   (s_head),
    .stage_o  (m_stage),
    .head_o   (m_head),
    .tail_o   (m_tail)
  );

  logic rise_w, fall_w;
  dcs_ddr_out u_out (
    .clk_fast (clk_fast),
    .rst      (rst),
    .pair_i   (m_head),
    .rise_o   (rise_w),
    .fall_o   (fall_w),
    .ser_o    (ser_out)
  );

endmodule

// File: rtl/dcs_checker.sv
`timescale 1ns/1ps
module dcs_checker #(
  parameter int WORD_W   = 8,
  parameter int MASTER_W = 6,
  parameter int PAIRS    = 4
) (
  input logic                       clk_fast,
  input logic                       rst,
  input logic                       load_w,
  input logic                       stage_en_w,
  input logic [WORD_W-1:0]          cap_q,
  input logic [MASTER_W-1:0]        m_stage,
  input logic [WORD_W-MASTER_W-1:0] s_stage,
  input logic [1:0]                 m_tail,
  input logic [1:0]                 s_head,
  input logic [1:0]                 s_tail,
  input logic                       rise_w,
  input logic                       fall_w
);
  localparam int GAP_W = $clog2(PAIRS) + 1;

  logic [GAP_W-1:0] gap_q;
  logic             seen_q;
  always_ff @(posedge clk_fast or posedge rst) begin
    if (rst) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (load_w) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != {GAP_W{1'b1}}) begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  always @(posedge clk_fast) begin
    if (rst) begin
      AST_RESET_QUIET: assert (rise_w == 1'b0 && fall_w == 1'b0); // R6
    end
  end

  AST_STAGE_CAPTURE: assert property (@(posedge clk_fast) disable iff (rst)
    stage_en_w |=> ({s_stage, m_stage} == $past(cap_q))); // R1

  AST_FIRST_BIT: assert property (@(posedge clk_fast) disable iff (rst)
    load_w |=> (rise_w == $past(m_stage[0]))); // R3

  AST_CASCADE_LINK: assert property (@(posedge clk_fast) disable iff (rst)
    !load_w |=> (m_tail == $past(s_head))); // R4

  AST_SLAVE_LOAD: assert property (@(posedge clk_fast) disable iff (rst)
    load_w |=> (s_head == $past(s_stage[1:0]))); // R4

  AST_SLAVE_DRAIN: assert property (@(posedge clk_fast) disable iff (rst)
    !load_w |=> (s_tail == 2'b00)); // R4

  AST_LOAD_PERIOD: assert property (@(posedge clk_fast) disable iff (rst)
    (load_w && seen_q) |-> (gap_q == GAP_W'(PAIRS - 1))); // R8

endmodule

bind ddr_cascade_serializer dcs_checker #(
  .WORD_W   (WORD_W),
  .MASTER_W (MASTER_W),
  .PAIRS    (PAIRS)
) i_dcs_checker (
  .clk_fast   (clk_fast),
  .rst        (rst),
  .load_w     (load_w),
  .stage_en_w (stage_en_w),
  .cap_q      (cap_q),
  .m_stage    (m_stage),
  .s_stage    (s_stage),
  .m_tail     (m_tail),
  .s_head     (s_head),
  .s_tail     (s_tail),
  .rise_w     (rise_w),
  .fall_w     (fall_w)
);

// File: tb/test_ddr_cascade_serializer.sv
`timescale 1ns/1ps
module test_ddr_cascade_serializer;

  logic       clk_fast = 1'b0;
  logic       clk_slow = 1'b0;
  logic       rst      = 1'b0;
  logic [7:0] par_din  = 8'h00;
  logic       ser_out;

  int  tests = 0;
  int  fails = 0;
  bit  done  = 1'b0;

  logic [7:0] captured [0:1023];
  int         edge_idx  = -1;
  realtime    rst_fall_t = -1.0e9;

  ddr_cascade_serializer i_ddr_cascade_serializer (
    .clk_fast (clk_fast),
    .clk_slow (clk_slow),
    .rst      (rst),
    .par_din  (par_din),
    .ser_out  (ser_out)
  );

  // 200 MHz bit clock; word clock at one quarter, rising edges aligned.
  always #2.5 clk_fast = ~clk_fast;
  initial begin
    #2.5 clk_slow = 1'b1;
    forever #10 clk_slow = ~clk_slow;
  end

  // Bench record of what each slow rising edge captures (R1).
  always @(posedge clk_slow) begin
    edge_idx++;
    if (edge_idx < 1024) captured[edge_idx] = rst ? 8'h00 : par_din;
  end

  always @(negedge rst) rst_fall_t = $realtime;

  function automatic real edge_time(input int k);
    return 2.5 + 20.0 * k;
  endfunction

  // Half-slot h carries bit (h mod 8) of the word captured one slow period
  // before its slot starts: four fast cycles of latency (R3), no gaps (R5).
  function automatic logic exp_bit(input int h, output string tag);
    int k, b;
    k = h / 8 - 1;
    b = h % 8;
    if (rst)                           begin tag = "R6"; return 1'b0; end
    if (k < 0)                         begin tag = "R6"; return 1'b0; end
    if (rst_fall_t > edge_time(k))     begin tag = "R7"; return 1'b0; end
    if (b == 0)      tag = "R3";
    else if (b >= 6) tag = "R4";
    else             tag = "R2";
    return captured[k][b];
  endfunction

  initial begin
    #3.75;
    for (int h = 0; !done; h++) begin
      string tag;
      logic  e;
      e = exp_bit(h, tag);
      tests++;
      if (ser_out !== e) begin
        fails++;
        $display("FAIL %s slot %0d bit %0d: got %b expected %b", tag, h, h % 8, ser_out, e);
      end
      #2.5;
    end
  end

  task automatic drive_word(input logic [7:0] w);
    par_din = w;
    @(posedge clk_slow);
    #1;
  endtask

  // Junk held between edges must not reach the stream (R1).
  task automatic drive_glitch(input logic [7:0] w, input logic [7:0] junk);
    par_din = junk;
    #8 par_din = ~junk;
    #6 par_din = w;
    @(posedge clk_slow);
    #1;
  endtask

  initial begin
    void'($urandom(32'd7341));
    #0.5 rst = 1'b1;                        // R6: checked by sampler during reset
    repeat (4) @(posedge clk_slow);
    #1 rst = 1'b0;
    // Directed corner words: single bits at both ends, slice boundaries.
    drive_word(8'h01); drive_word(8'h80); drive_word(8'hFF); drive_word(8'h00);
    drive_word(8'h3F); drive_word(8'hC0); drive_word(8'h55); drive_word(8'hAA);
    drive_word(8'h40); drive_word(8'h02);
    drive_glitch(8'h96, 8'h5A);
    drive_glitch(8'h00, 8'hFF);
    for (int i = 0; i < 200; i++) drive_word(8'($urandom));
    // Mid-stream reset: in-flight and in-reset words must be flushed (R7).
    rst = 1'b1;
    for (int i = 0; i < 3; i++) drive_word(8'($urandom) | 8'h01);
    rst = 1'b0;
    for (int i = 0; i < 40; i++) drive_word(8'($urandom));
    for (int i = 0; i < 3; i++) drive_word(8'h00);
    done = 1'b1;
    #5;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule